// File: doc/BRIEF.md
# Banked data address generator

This block turns the short data-address field of a small 8-bit core into a full 12-bit address for a 4096-byte data space laid out as 16 pages of 256 bytes. An instruction's address field holds only 8 bits, so the four upper bits must come from somewhere else. A per-access select bit chooses between two mappings. The first is a fixed window whose lower half reaches the bottom of general RAM and whose upper half reaches the special-register area at the top of the space. The second is a page register that supplies the upper nibble. Software loads the page register either with a full-byte register write or with a short immediate-load command.

A second path serves memory-to-memory moves. Such a move carries two complete 12-bit addresses and bypasses the page register completely. A two-state controller issues the source address and then, on the following cycle, the destination address. Each address leaves the block registered, one cycle after its request, together with a flag that marks the special-register region and a code that says which kind of access produced it.

The move controller has two states. ST_IDLE accepts direct accesses and move starts. ST_DST emits the held destination address. There are two transitions. "start-move" goes from ST_IDLE to ST_DST when a move start is seen in ST_IDLE. "finish-move" goes from ST_DST back to ST_IDLE unconditionally after one cycle.

Top module: `bank_addr_gen`

## Requirements
- R1: With acc_banked=0 and an offset of 0x00 to 0x7F, the address is 0x000 plus the offset, whatever the page register holds.
- R2: With acc_banked=0 and an offset of 0x80 to 0xFF, the address is 0xF80 plus (offset − 0x80), so the upper nibble is 0xF.
- R3: With acc_banked=1, the address is {bank_q[3:0], offset}. Bits 7:4 of the page register have no effect on it.
- R4: bank_wr_en loads all 8 bits of bank_wr_data into the page register, which bank_q shows from the next cycle on. The page register is 0x00 after reset.
- R5: bank_imm_en loads {4'b0000, bank_imm_lit} into the page register. When bank_wr_en is high in the same cycle, the full-byte write wins.
- R6: A direct access made in the same cycle as a page-register load uses the page value from before the load.
- R7: ea_sfr is 1 exactly when ea_addr lies in 0xF80 to 0xFFF, for every kind of access.
- R8: mv_start in ST_IDLE puts mv_src on ea_addr with ea_kind=1 after the next edge, and mv_dst with ea_kind=2 one edge later. Neither address depends on the page register or on acc_banked.
- R9: In ST_IDLE, mv_start takes precedence over acc_req. In ST_DST (mv_busy=1), both acc_req and mv_start are ignored.
- R10: A result appears one edge after its request, with ea_kind 0 for direct, 1 for move source and 2 for move destination. ea_valid is 0 in any cycle that follows no request.
- R11: After reset, ea_valid=0, ea_addr=0x000, ea_kind=0, mv_busy=0 and bank_q=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Direct access request |
| acc_ofs | input | 8 | Address field taken from the instruction |
| acc_banked | input | 1 | 0: fixed window, 1: page register supplies bits 11:8 |
| bank_wr_en | input | 1 | Full-byte write to the page register |
| bank_wr_data | input | 8 | Data for the full-byte write |
| bank_imm_en | input | 1 | Immediate page load |
| bank_imm_lit | input | 4 | Page literal for the immediate load |
| mv_start | input | 1 | Start a memory-to-memory move |
| mv_src | input | 12 | Full source address of the move |
| mv_dst | input | 12 | Full destination address of the move |
| ea_valid | output | 1 | ea_addr holds a new address |
| ea_addr | output | 12 | Effective data address |
| ea_sfr | output | 1 | Address falls in the special-register region |
| ea_kind | output | 2 | 0 direct, 1 move source, 2 move destination |
| mv_busy | output | 1 | Controller is in ST_DST |
| bank_q | output | 8 | Current page register value |

## Verification
The properties take for granted that every input is at a known level at each rising edge once reset is released, and that a request lasts exactly the cycles it is meant to count for. Several checks compare the result with $past of the inputs, so an unknown or glitching request would make them meaningless. The bench gives every input a defined value from time zero, holds all requests low through reset, and changes inputs only 2 ns after a rising edge. Request lines are cleared again before the cycle in which the bench reads the result.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;

    // Which path produced the registered address.
    typedef enum logic [1:0] {
        EA_DIRECT = 2'd0,
        EA_MV_SRC = 2'd1,
        EA_MV_DST = 2'd2
    } ea_kind_e;

    // Move controller states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DST  = 1'b1
    } mv_state_e;

endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
    parameter int REG_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              imm_en,
    input  logic [BANK_W-1:0] imm_lit,
    output logic [REG_W-1:0]  bank_q
);

    logic [REG_W-1:0] bank_nxt;

    // Full-byte write outranks the immediate load.
    always_comb begin
        bank_nxt = bank_q;
        if (wr_en) begin
            bank_nxt = wr_data;
        end else if (imm_en) begin
            bank_nxt = {{(REG_W-BANK_W){1'b0}}, imm_lit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_nxt;
        end
    end

endmodule

// File: rtl/access_mapper.sv
module access_mapper #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 8
) (
    input  logic [OFS_W-1:0]        ofs,
    input  logic                    banked,
    input  logic [ADDR_W-OFS_W-1:0] bank,
    output logic [ADDR_W-1:0]       addr
);

    localparam int BANK_W = ADDR_W - OFS_W;

    logic [BANK_W-1:0] win_page;

    // Fixed window: the upper half of the offsets folds onto the top page.
    assign win_page = ofs[OFS_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

    always_comb begin
        if (banked) begin
            addr = {bank, ofs};
        end else begin
            addr = {win_page, ofs};
        end
    end

endmodule

// File: rtl/move_seq.sv
module move_seq
    import bank_addr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dst,
    output logic              take_move,
    output logic              emit_dst,
    output logic [ADDR_W-1:0] dst_hold
);

    mv_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dst_hold <= '0;
        end else begin
            state_q <= state_d;
            if (take_move) begin
                dst_hold <= dst;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        take_move = 1'b0;
        emit_dst  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    take_move = 1'b1;
                    state_d   = ST_DST;   // start-move
                end
            end
            ST_DST: begin
                emit_dst = 1'b1;
                state_d  = ST_IDLE;       // finish-move
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_addr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 8,
    parameter int REG_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_req,
    input  logic [OFS_W-1:0]        acc_ofs,
    input  logic                    acc_banked,
    input  logic                    bank_wr_en,
    input  logic [REG_W-1:0]        bank_wr_data,
    input  logic                    bank_imm_en,
    input  logic [ADDR_W-OFS_W-1:0] bank_imm_lit,
    input  logic                    mv_start,
    input  logic [ADDR_W-1:0]       mv_src,
    input  logic [ADDR_W-1:0]       mv_dst,
    output logic                    ea_valid,
    output logic [ADDR_W-1:0]       ea_addr,
    output logic                    ea_sfr,
    output logic [1:0]              ea_kind,
    output logic                    mv_busy,
    output logic [REG_W-1:0]        bank_q
);

    localparam int BANK_W = ADDR_W - OFS_W;
    localparam int SFR_LO = OFS_W - 1;   // region = top half-page

    logic [ADDR_W-1:0] dir_addr;
    logic              take_move;
    logic              emit_dst;
    logic [ADDR_W-1:0] dst_hold;
    logic              nxt_valid;
    logic [ADDR_W-1:0] nxt_addr;
    ea_kind_e          nxt_kind;
    logic              nxt_sfr;

    bank_sel_reg #(.REG_W(REG_W), .BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .wr_data (bank_wr_data),
        .imm_en  (bank_imm_en),
        .imm_lit (bank_imm_lit),
        .bank_q  (bank_q)
    );

    access_mapper #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_map (
        .ofs    (acc_ofs),
        .banked (acc_banked),
        .bank   (bank_q[BANK_W-1:0]),
        .addr   (dir_addr)
    );

    move_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mv_start),
        .dst       (mv_dst),
        .take_move (take_move),
        .emit_dst  (emit_dst),
        .dst_hold  (dst_hold)
    );

    // Source select: destination phase, then move start, then direct access.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_addr  = '0;
        nxt_kind  = EA_DIRECT;
        if (emit_dst) begin
            nxt_valid = 1'b1;
            nxt_addr  = dst_hold;
            nxt_kind  = EA_MV_DST;
        end else if (take_move) begin
            nxt_valid = 1'b1;
            nxt_addr  = mv_src;
            nxt_kind  = EA_MV_SRC;
        end else if (acc_req) begin
            nxt_valid = 1'b1;
            nxt_addr  = dir_addr;
            nxt_kind  = EA_DIRECT;
        end
    end

    assign nxt_sfr = &nxt_addr[ADDR_W-1:SFR_LO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea_addr  <= '0;
            ea_sfr   <= 1'b0;
            ea_kind  <= EA_DIRECT;
        end else begin
            ea_valid <= nxt_valid;
            ea_kind  <= nxt_kind;
            if (nxt_valid) begin
                ea_addr <= nxt_addr;
                ea_sfr  <= nxt_sfr;
            end
        end
    end

    assign mv_busy = emit_dst;

endmodule

// File: rtl/bank_addr_chk.sv
module bank_addr_chk #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 8,
    parameter int REG_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_req,
    input logic [OFS_W-1:0]        acc_ofs,
    input logic                    acc_banked,
    input logic                    bank_wr_en,
    input logic [REG_W-1:0]        bank_wr_data,
    input logic                    bank_imm_en,
    input logic [ADDR_W-OFS_W-1:0] bank_imm_lit,
    input logic                    mv_start,
    input logic [ADDR_W-1:0]       mv_src,
    input logic [ADDR_W-1:0]       mv_dst,
    input logic                    ea_valid,
    input logic [ADDR_W-1:0]       ea_addr,
    input logic                    ea_sfr,
    input logic [1:0]              ea_kind,
    input logic                    mv_busy,
    input logic [REG_W-1:0]        bank_q
);

    localparam int BANK_W = ADDR_W - OFS_W;
    localparam logic [ADDR_W-1:0] SFR_BASE = ADDR_W'((1 << ADDR_W) - (1 << (OFS_W - 1)));

    // R1 R2
    window_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !mv_start && !mv_busy && !acc_banked) |=>
        (ea_valid && ea_kind == 2'd0 &&
         ea_addr == ($past(acc_ofs) < (1 << (OFS_W - 1)) ? ADDR_W'($past(acc_ofs))
                     : SFR_BASE + ADDR_W'($past(acc_ofs)) - ADDR_W'(1 << (OFS_W - 1)))));

    // R3 R6
    banked_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !mv_start && !mv_busy && acc_banked) |=>
        (ea_valid && ea_addr[OFS_W-1:0] == $past(acc_ofs) &&
         ea_addr[ADDR_W-1:OFS_W] == $past(bank_q[BANK_W-1:0])));

    // R5
    bank_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_imm_en && !bank_wr_en) |=>
        (bank_q == {{(REG_W-BANK_W){1'b0}}, $past(bank_imm_lit)}));

    // R4
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_en |=> (bank_q == $past(bank_wr_data)));

    // R7
    sfr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> (ea_sfr == (ea_addr >= SFR_BASE)));

    // R8
    move_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_start && !mv_busy) |=>
        (ea_valid && ea_kind == 2'd1 && ea_addr == $past(mv_src) && mv_busy));

    // R8 R9
    move_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_busy |=> (ea_valid && ea_kind == 2'd2 && !mv_busy));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req && !mv_start && !mv_busy) |=> !ea_valid);

endmodule

bind bank_addr_gen bank_addr_chk #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .REG_W(REG_W)
) u_chk (.*);

// File: tb/bank_addr_gen_tb_top.sv
`timescale 1ns/1ps
module bank_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [7:0]  acc_ofs = '0;
    logic        acc_banked = 1'b0;
    logic        bank_wr_en = 1'b0;
    logic [7:0]  bank_wr_data = '0;
    logic        bank_imm_en = 1'b0;
    logic [3:0]  bank_imm_lit = '0;
    logic        mv_start = 1'b0;
    logic [11:0] mv_src = '0;
    logic [11:0] mv_dst = '0;
    logic        ea_valid;
    logic [11:0] ea_addr;
    logic        ea_sfr;
    logic [1:0]  ea_kind;
    logic        mv_busy;
    logic [7:0]  bank_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_ofs(acc_ofs),
        .acc_banked(acc_banked), .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
        .bank_imm_en(bank_imm_en), .bank_imm_lit(bank_imm_lit), .mv_start(mv_start),
        .mv_src(mv_src), .mv_dst(mv_dst), .ea_valid(ea_valid), .ea_addr(ea_addr),
        .ea_sfr(ea_sfr), .ea_kind(ea_kind), .mv_busy(mv_busy), .bank_q(bank_q)
    );

    // {banked, page, offset, expected addr, expected sfr}
    localparam int NV = 10;
    localparam logic [NV-1:0][29:0] VEC = {
        {1'b0, 8'h00, 8'h00, 12'h000, 1'b0},  // R1
        {1'b0, 8'h00, 8'h7F, 12'h07F, 1'b0},  // R1
        {1'b0, 8'h00, 8'h80, 12'hF80, 1'b1},  // R2
        {1'b0, 8'h00, 8'hFF, 12'hFFF, 1'b1},  // R2
        {1'b0, 8'h03, 8'h45, 12'h045, 1'b0},  // R1 page ignored
        {1'b1, 8'h02, 8'h40, 12'h240, 1'b0},  // R3
        {1'b1, 8'hF5, 8'h12, 12'h512, 1'b0},  // R3 upper nibble ignored
        {1'b1, 8'h0F, 8'h80, 12'hF80, 1'b1},  // R3 R7
        {1'b1, 8'h0F, 8'h7F, 12'hF7F, 1'b0},  // R3 R7
        {1'b1, 8'h00, 8'hC0, 12'h0C0, 1'b0}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 valid", ea_valid, 0);
        chk("R11 addr", ea_addr, 0);
        chk("R11 kind", ea_kind, 0);
        chk("R11 busy", mv_busy, 0);
        chk("R11 R4 bank", bank_q, 0);

        for (int i = NV - 1; i >= 0; i--) begin
            bank_wr_en = 1'b1; bank_wr_data = VEC[i][28:21];
            step();
            bank_wr_en = 1'b0;
            chk("R4 bank load", bank_q, VEC[i][28:21]);
            acc_req = 1'b1; acc_banked = VEC[i][29]; acc_ofs = VEC[i][20:13];
            step();
            acc_req = 1'b0;
            chk("R1 R2 R3 addr", ea_addr, VEC[i][12:1]);
            chk("R7 sfr", ea_sfr, VEC[i][0]);
            chk("R10 kind direct", {ea_valid, ea_kind}, 3'b100);
            step();
            chk("R10 no request", ea_valid, 0);
        end

        // R5 immediate load clears upper nibble
        bank_wr_en = 1'b1; bank_wr_data = 8'hA3; step();
        bank_wr_en = 1'b0; bank_imm_en = 1'b1; bank_imm_lit = 4'h6; step();
        bank_imm_en = 1'b0;
        chk("R5 imm load", bank_q, 8'h06);
        // R5 full write wins
        bank_wr_en = 1'b1; bank_wr_data = 8'h2C; bank_imm_en = 1'b1; bank_imm_lit = 4'h9;
        step();
        bank_wr_en = 1'b0; bank_imm_en = 1'b0;
        chk("R5 priority", bank_q, 8'h2C);

        // R6 same-cycle load uses old page
        bank_imm_en = 1'b1; bank_imm_lit = 4'h7;
        acc_req = 1'b1; acc_banked = 1'b1; acc_ofs = 8'h33;
        step();
        bank_imm_en = 1'b0;
        chk("R6 old page", ea_addr, 12'hC33);
        step();
        acc_req = 1'b0;
        chk("R6 new page", ea_addr, 12'h733);

        // R8 R9 move with a competing direct access
        mv_start = 1'b1; mv_src = 12'hFA0; mv_dst = 12'h0C3;
        acc_req = 1'b1; acc_banked = 1'b1; acc_ofs = 8'h11;
        step();
        chk("R8 src addr", ea_addr, 12'hFA0);
        chk("R8 R9 src kind", {ea_valid, ea_kind}, 3'b101);
        chk("R7 move sfr", ea_sfr, 1);
        chk("R8 busy", mv_busy, 1);
        mv_src = 12'h111; mv_dst = 12'h222;  // ignored while busy
        step();
        mv_start = 1'b0; acc_req = 1'b0;
        chk("R8 R9 dst addr", ea_addr, 12'h0C3);
        chk("R8 dst kind", {ea_valid, ea_kind}, 3'b110);
        chk("R7 dst sfr", ea_sfr, 0);
        chk("R9 busy clears", mv_busy, 0);
        step();
        chk("R9 R10 no extra output", ea_valid, 0);
        chk("R8 page untouched", bank_q, 8'h07);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule